// File: doc/BRIEF.md
# Supervisor Access Protection Control State

This block keeps the privileged control state that decides how supervisor-mode accesses to user pages are policed. It holds a 32-bit protection control register that software writes with a single strobe. Before a write is stored, the register bits for features the core does not support are forced to zero. The block keeps two shadow flags that copy the stored extended-state-save enable and the supervisor-access-prevention enable. It asks the translation cache to flush whenever a write changes one of the bits that affect page protection.

The block also carries the access-override flag, which is bit 18 of the processor status word. Two single-cycle instructions clear or set this flag. Each one is checked first: it runs only when access prevention is supported and the current privilege level is 0. Otherwise the flag is left alone and a one-cycle illegal-opcode pulse is raised. All state updates take effect on the clock edge that samples the strobe. The two pulses are registered and are high for exactly the one cycle after that edge.

Top module: `supv_prot_state`

## Requirements
- R1: While reset is low and in the first cycle after it is released, the control register, the override flag, both shadow flags, the flush pulse and the illegal-opcode pulse are all zero.
- R2: When the write strobe is high at a clock edge, the masked write data appears on the control register output after that edge. With the strobe low, the control register does not change.
- R3: When the feature input bit 1 (access prevention supported) is 0, control register bit 21 (access-prevention enable) is stored as 0 whatever the write data holds.
- R4: When the feature input bit 0 (extended state save supported) is 0, control register bit 9 is stored as 0. Every other bit, including bit 20 (execution-prevention enable), is stored as written.
- R5: After every write, shadowFx equals stored bit 9 and shadowAp equals stored bit 21.
- R6: After a write, flushPulse is high for exactly one cycle if any of control bits 4, 5, 7, 20 or 21 differs between the old stored value and the masked new value. If none of them differs, flushPulse stays low.
- R7: A legal clear strobe makes the override flag 0, and a legal set strobe makes it 1, from the next edge.
- R8: A clear or set strobe is legal only when feature bit 1 is 1 and privLvl is 0. An illegal strobe leaves the override flag unchanged and makes illegalOp high for exactly one cycle after the edge.
- R9: When the clear and set strobes are both high and legal in the same cycle, the clear wins and the flag becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctlWrEn | input | 1 | Control register write strobe |
| ctlWrData | input | 32 | Control register write data |
| featVec | input | 2 | Supported features: bit 0 extended state save, bit 1 access prevention |
| privLvl | input | 2 | Current privilege level |
| clrOvrdReq | input | 1 | Clear-override instruction strobe |
| setOvrdReq | input | 1 | Set-override instruction strobe |
| ctlReg | output | 32 | Stored control register |
| ovrdFlag | output | 1 | Access-override flag (status bit 18) |
| shadowFx | output | 1 | Shadow of stored bit 9 |
| shadowAp | output | 1 | Shadow of stored bit 21 |
| flushPulse | output | 1 | One-cycle translation-cache flush request |
| illegalOp | output | 1 | One-cycle illegal-opcode pulse |

## Verification
The write path is tested with all 64 combinations of the six bits that matter (4, 5, 7, 9, 20, 21). These are mixed with shifting filler in the other bits and applied under each of the four feature settings. Checking the flush against the arithmetic model separates a real toggle from one that masking removed, and separates protection bits from filler. The instruction path is tested over every privilege level, feature setting and strobe combination. Each strobe starts from the flag value it would change, so a wrongly executed illegal strobe shows up in the flag, and the case with both strobes high shows which one wins.

// File: rtl/supv_prot_pkg.sv
package supv_prot_pkg;
  // control register bit positions that the protection logic decodes
  localparam int PSE_BIT  = 4;
  localparam int PAE_BIT  = 5;
  localparam int PGE_BIT  = 7;
  localparam int FXSR_BIT = 9;
  localparam int XP_BIT   = 20;
  localparam int AP_BIT   = 21;
  // feature vector layout
  localparam int FEAT_SSE = 0;
  localparam int FEAT_AP  = 1;
  localparam int FEAT_W   = 2;
  localparam int NUM_PROT = 5;

  typedef struct packed {
    logic wrCtl;
    logic clrOvrd;
    logic setOvrd;
  } dpStrobe_t;

  function automatic int protBitPos(input int idx);
    case (idx)
      0: return PSE_BIT;
      1: return PAE_BIT;
      2: return PGE_BIT;
      3: return XP_BIT;
      default: return AP_BIT;
    endcase
  endfunction
endpackage

// File: rtl/supv_prot_ctrl.sv
module supv_prot_ctrl
  import supv_prot_pkg::*;
#(
  parameter int PRIV_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctlWrEn,
  input  logic              clrReq,
  input  logic              setReq,
  input  logic [PRIV_W-1:0] privLvl,
  input  logic              featAp,
  output dpStrobe_t         st,
  output logic              illegalOp
);
  logic opLegal;
  logic anyOp;

  assign opLegal = featAp && (privLvl == '0);
  assign anyOp   = clrReq || setReq;

  always_comb begin
    st.wrCtl   = ctlWrEn;
    st.clrOvrd = clrReq && opLegal;
    st.setOvrd = setReq && opLegal && !clrReq;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) illegalOp <= 1'b0;
    else        illegalOp <= anyOp && !opLegal;
  end

  // R8
  illegal_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegalOp |-> $past(anyOp && (!featAp || privLvl != '0)));

  // R8
  legal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (anyOp && featAp && privLvl == '0) |=> !illegalOp);
endmodule

// File: rtl/supv_prot_dp.sv
module supv_prot_dp
  import supv_prot_pkg::*;
#(
  parameter int CTL_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpStrobe_t         st,
  input  logic [CTL_W-1:0]  wrData,
  input  logic [FEAT_W-1:0] featVec,
  output logic [CTL_W-1:0]  ctlReg,
  output logic              ovrdFlag,
  output logic              shadowFx,
  output logic              shadowAp,
  output logic              flushPulse
);
  logic [CTL_W-1:0] maskedWr;
  logic [CTL_W-1:0] diffBits;
  logic [NUM_PROT-1:0] protDiff;

  always_comb begin
    maskedWr = wrData;
    if (!featVec[FEAT_SSE]) maskedWr[FXSR_BIT] = 1'b0;
    if (!featVec[FEAT_AP])  maskedWr[AP_BIT]   = 1'b0;
  end

  assign diffBits = maskedWr ^ ctlReg;

  for (genvar g = 0; g < NUM_PROT; g++) begin : g_prot
    assign protDiff[g] = diffBits[protBitPos(g)];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctlReg     <= '0;
      shadowFx   <= 1'b0;
      shadowAp   <= 1'b0;
      flushPulse <= 1'b0;
    end else begin
      flushPulse <= st.wrCtl && (|protDiff);
      if (st.wrCtl) begin
        ctlReg   <= maskedWr;
        shadowFx <= maskedWr[FXSR_BIT];
        shadowAp <= maskedWr[AP_BIT];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          ovrdFlag <= 1'b0;
    else if (st.clrOvrd) ovrdFlag <= 1'b0;
    else if (st.setOvrd) ovrdFlag <= 1'b1;
  end

  // R2
  hold_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !st.wrCtl |=> $stable(ctlReg));

  // R3
  ap_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st.wrCtl && !featVec[FEAT_AP]) |=> !ctlReg[AP_BIT]);

  // R5
  shadow_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shadowAp == ctlReg[AP_BIT]) && (shadowFx == ctlReg[FXSR_BIT]));

  // R6
  flush_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flushPulse |-> $past(st.wrCtl));

  // R9
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st.clrOvrd |=> !ovrdFlag);
endmodule

// File: rtl/supv_prot_state.sv
module supv_prot_state
  import supv_prot_pkg::*;
#(
  parameter int CTL_W  = 32,
  parameter int PRIV_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctlWrEn,
  input  logic [CTL_W-1:0]  ctlWrData,
  input  logic [FEAT_W-1:0] featVec,
  input  logic [PRIV_W-1:0] privLvl,
  input  logic              clrOvrdReq,
  input  logic              setOvrdReq,
  output logic [CTL_W-1:0]  ctlReg,
  output logic              ovrdFlag,
  output logic              shadowFx,
  output logic              shadowAp,
  output logic              flushPulse,
  output logic              illegalOp
);
  dpStrobe_t st;

  supv_prot_ctrl #(.PRIV_W(PRIV_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctlWrEn   (ctlWrEn),
    .clrReq    (clrOvrdReq),
    .setReq    (setOvrdReq),
    .privLvl   (privLvl),
    .featAp    (featVec[FEAT_AP]),
    .st        (st),
    .illegalOp (illegalOp)
  );

  supv_prot_dp #(.CTL_W(CTL_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .st         (st),
    .wrData     (ctlWrData),
    .featVec    (featVec),
    .ctlReg     (ctlReg),
    .ovrdFlag   (ovrdFlag),
    .shadowFx   (shadowFx),
    .shadowAp   (shadowAp),
    .flushPulse (flushPulse)
  );
endmodule

// File: tb/supv_prot_state_bench.sv
`timescale 1ns/1ps
module supv_prot_state_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctlWrEn;
  logic [31:0] ctlWrData;
  logic [1:0]  featVec;
  logic [1:0]  privLvl;
  logic        clrOvrdReq;
  logic        setOvrdReq;
  logic [31:0] ctlReg;
  logic        ovrdFlag, shadowFx, shadowAp, flushPulse, illegalOp;

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 0;
  logic [31:0] expCtl = '0;
  logic        expFlag = 1'b0;

  always #4 clk = ~clk;

  supv_prot_state u_supv_prot_state (
    .clk(clk), .rst_n(rst_n), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .featVec(featVec), .privLvl(privLvl), .clrOvrdReq(clrOvrdReq),
    .setOvrdReq(setOvrdReq), .ctlReg(ctlReg), .ovrdFlag(ovrdFlag),
    .shadowFx(shadowFx), .shadowAp(shadowAp), .flushPulse(flushPulse),
    .illegalOp(illegalOp)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [31:0] data, input logic [1:0] feat);
    logic [31:0] masked;
    logic        expFl;
    masked = data;
    if (!feat[0]) masked[9]  = 1'b0;
    if (!feat[1]) masked[21] = 1'b0;
    expFl = |((masked ^ expCtl) & 32'h0030_00B0);
    @(negedge clk);
    featVec = feat; ctlWrData = data; ctlWrEn = 1'b1;
    @(negedge clk);
    ctlWrEn = 1'b0;
    expCtl = masked;
    chk(ctlReg == expCtl, "R2/R3/R4 stored value", ctlReg, expCtl);
    chk({shadowFx, shadowAp} == {expCtl[9], expCtl[21]}, "R5 shadows",
        {30'd0, shadowFx, shadowAp}, {30'd0, expCtl[9], expCtl[21]});
    chk(flushPulse == expFl, "R6 flush", {31'd0, flushPulse}, {31'd0, expFl});
    @(negedge clk);
    chk(flushPulse == 1'b0, "R6 flush one cycle", {31'd0, flushPulse}, 32'd0);
    chk(ctlReg == expCtl, "R2 hold without strobe", ctlReg, expCtl);
  endtask

  task automatic doOp(input bit clr, input bit set, input logic [1:0] priv,
                      input logic [1:0] feat, input bit checkIt);
    bit legal;
    legal = feat[1] && (priv == 2'd0);
    @(negedge clk);
    featVec = feat; privLvl = priv; clrOvrdReq = clr; setOvrdReq = set;
    @(negedge clk);
    clrOvrdReq = 1'b0; setOvrdReq = 1'b0;
    if (legal) expFlag = clr ? 1'b0 : 1'b1;
    if (checkIt) begin
      chk(ovrdFlag == expFlag, legal ? (clr && set ? "R9 clear wins" : "R7 flag update")
                                     : "R8 illegal leaves flag",
          {31'd0, ovrdFlag}, {31'd0, expFlag});
      chk(illegalOp == !legal, "R8 illegal pulse", {31'd0, illegalOp},
          {31'd0, !legal});
    end
    @(negedge clk);
    if (checkIt)
      chk(illegalOp == 1'b0, "R8 illegal pulse one cycle", {31'd0, illegalOp}, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; ctlWrEn = 1'b0; ctlWrData = '0; featVec = '0; privLvl = '0;
    clrOvrdReq = 1'b0; setOvrdReq = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({ctlReg, ovrdFlag, shadowFx, shadowAp, flushPulse, illegalOp} == '0,
        "R1 reset state", ctlReg, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({ovrdFlag, shadowFx, shadowAp, flushPulse, illegalOp} == '0 && ctlReg == '0,
        "R1 after release", ctlReg, 32'd0);

    // write sweep: every combination of bits 4,5,7,9,20,21 under each feature set
    for (int f = 0; f < 4; f++) begin
      for (int i = 0; i < 64; i++) begin
        logic [31:0] d;
        d = (32'(i + 64 * f) * 32'h9E37_79B1) & ~32'h0030_02B0;
        d[4] = i[0]; d[5] = i[1]; d[7] = i[2];
        d[9] = i[3]; d[20] = i[4]; d[21] = i[5];
        doWrite(d, 2'(f));
      end
    end
    // same value twice: no flush (R6)
    doWrite(32'h0030_02B0, 2'b11);
    doWrite(32'h0030_02B0, 2'b11);
    // only non-protection bits change: no flush (R6)
    doWrite(32'h0F30_02B0, 2'b11);

    // instruction sweep (R7, R8, R9)
    for (int f = 0; f < 4; f++) begin
      for (int p = 0; p < 4; p++) begin
        for (int op = 1; op < 4; op++) begin
          bit c, s;
          c = op[0]; s = op[1];
          // bring the flag to the value this strobe would change
          doOp(!c, c, 2'd0, 2'b10, 1'b0);
          doOp(c, s, 2'(p), 2'(f), 1'b1);
        end
      end
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end
endmodule